// File: doc/BRIEF.md
# RTC Alarm Comparator and Interrupt Controller

This block sits beside a real-time clock counter that keeps time and date as packed BCD words. It holds two alarm words: one for time of day and one for the calendar. Each alarm field carries its own enable bit. Every cycle the block compares the enabled fields against the running words. When they first agree, it raises a sticky alarm flag.

The alarm flag shares a five-bit status vector with four event inputs from the counter: update acknowledge, second, time and calendar. Software changes the interrupt mask only through two strobe addresses. A one written to the enable address sets the matching mask bit, and a one written to the disable address clears it. Status bits are cleared the same way, through a clear address. A single level interrupt is high while any masked status bit is set.

A combinational validity vector reports BCD entries that are out of range or that have reserved bits set. This covers the current time, the current calendar and both alarm words. An alarm word that fails this check cannot fire.

Top module: `rtcal_top`

## Requirements
- R1: Time alarm word (write address 0): seconds in bits [6:0] with enable bit 7, minutes in bits [14:8] with enable bit 15, hours in bits [21:16] with enable bit 23. The seconds, minutes and hours fields of the current time sit at the same positions. A field whose enable is 0 takes no part in the compare.
- R2: Calendar alarm word (write address 1): month in bits [20:16] with enable bit 23, date in bits [29:24] with enable bit 31. The current calendar word has the same month and date positions, and its century [6:0], year [15:8] and weekday [23:21] never take part in the compare.
- R3: Status bit 1 (alarm) sets one cycle after the cycle in which, with at least one field enabled, all enabled fields first agree. It does not set again while that agreement continues, even after it has been cleared. It sets again only after the agreement has broken and been restored.
- R4: A one on ev_upd_ack, ev_second, ev_time or ev_cal sets status bit 0, 2, 3 or 4 respectively one cycle later. The bit stays set until it is cleared.
- R5: A write to address 2 sets each mask bit whose data bit is 1, and leaves every mask bit whose data bit is 0 unchanged.
- R6: A write to address 3 clears each mask bit whose data bit is 1, and leaves every mask bit whose data bit is 0 unchanged.
- R7: A write to address 4 clears each status bit whose data bit is 1, and leaves the other status bits unchanged.
- R8: When a status bit is set and cleared in the same cycle, it ends up set.
- R9: irq is high exactly when some status bit and its mask bit are both 1. It follows status and mask with no added delay.
- R10: entry_bad flags problems in four words. Bit 0 covers the current time: sec or min above 0x59, hour above 0x23, a nibble above 9, or any of bits 7, 15 or [31:22] set. Bit 1 covers the current calendar: month outside 0x01..0x12, date outside 0x01..0x31, weekday outside 1..7, a bad BCD year or century, or any of bits 7 or [31:30] set. Bit 2 covers the time alarm: an enabled field out of range, or bit 22 or [31:24] set. Bit 3 covers the calendar alarm: an enabled field out of range, or bit 30, [22:21] or [15:0] set.
- R11: While entry_bad bit 2 or 3 is set, the alarm status bit does not set.
- R12: After reset, status, mask, both alarm words and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_time | input | 32 | Running BCD time word |
| cur_cal | input | 32 | Running BCD calendar word |
| ev_upd_ack | input | 1 | Update-acknowledge event pulse |
| ev_second | input | 1 | Second event pulse |
| ev_time | input | 1 | Time event pulse |
| ev_cal | input | 1 | Calendar event pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Write address (0..4) |
| reg_wdata | input | 32 | Write data |
| alarm_time_word | output | 32 | Stored time alarm word |
| alarm_cal_word | output | 32 | Stored calendar alarm word |
| status | output | 5 | Sticky event status |
| irq_mask | output | 5 | Interrupt mask |
| entry_bad | output | 4 | Validity flags |
| irq | output | 1 | Level interrupt |

## Verification
Writes, event pulses and alarm matches all take effect through one register. Their results on status, irq_mask and the alarm words are therefore due one clock edge after the cycle that carries the stimulus. entry_bad and irq are combinational from the inputs and those registers, so they are due as soon as those have settled. The bench drives every input 1 ns after a rising edge. It checks registered results 1 ns after the next rising edge, and it checks combinational results in the same window, before any input moves again. Each alarm vector first parks the inputs on a non-matching baseline, so that the one-cycle match pulse is seen fresh.

// File: rtl/rtcal_pkg.sv
package rtcal_pkg;

    localparam int NSRC    = 5;
    localparam int WORD_W  = 32;
    localparam int NCHK    = 4;

    localparam int SRC_UPD = 0;
    localparam int SRC_ALM = 1;
    localparam int SRC_SEC = 2;
    localparam int SRC_TIM = 3;
    localparam int SRC_CAL = 4;

    localparam int BAD_TIME = 0;
    localparam int BAD_CAL  = 1;
    localparam int BAD_TALM = 2;
    localparam int BAD_CALM = 3;

    typedef enum logic [2:0] {
        RA_TIME_ALM = 3'd0,
        RA_CAL_ALM  = 3'd1,
        RA_IRQ_SET  = 3'd2,
        RA_IRQ_CLR  = 3'd3,
        RA_STAT_CLR = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [5:0] hour;
        logic [6:0] min;
        logic [6:0] sec;
    } time_f_t;

    typedef struct packed {
        logic [5:0] date;
        logic [4:0] mon;
    } cal_f_t;

    typedef struct packed {
        logic    hour_en;
        logic    min_en;
        logic    sec_en;
        time_f_t val;
    } talm_f_t;

    typedef struct packed {
        logic   date_en;
        logic   mon_en;
        cal_f_t val;
    } calm_f_t;

    function automatic logic bcd_in_range(input logic [7:0] v,
                                          input logic [7:0] lo,
                                          input logic [7:0] hi);
        return (v[3:0] <= 4'd9) && (v >= lo) && (v <= hi);
    endfunction

endpackage

// File: rtl/rtcal_entry_check.sv
module rtcal_entry_check
    import rtcal_pkg::*;
(
    input  logic [WORD_W-1:0] cur_time,
    input  logic [WORD_W-1:0] cur_cal,
    input  logic [WORD_W-1:0] talm_w,
    input  logic [WORD_W-1:0] calm_w,
    output logic [NCHK-1:0]   bad
);

    logic t_sec_ok, t_min_ok, t_hour_ok, t_rsv;
    logic c_cent_ok, c_year_ok, c_day_ok, c_mon_ok, c_date_ok, c_rsv;
    logic a_sec_ok, a_min_ok, a_hour_ok, a_rsv;
    logic m_mon_ok, m_date_ok, m_rsv;

    always_comb begin
        t_sec_ok  = bcd_in_range({1'b0, cur_time[6:0]},   8'h00, 8'h59);
        t_min_ok  = bcd_in_range({1'b0, cur_time[14:8]},  8'h00, 8'h59);
        t_hour_ok = bcd_in_range({2'b0, cur_time[21:16]}, 8'h00, 8'h23);
        t_rsv     = cur_time[7] | cur_time[15] | (|cur_time[31:22]);

        c_cent_ok = bcd_in_range({1'b0, cur_cal[6:0]},   8'h00, 8'h79);
        c_year_ok = bcd_in_range(cur_cal[15:8],          8'h00, 8'h99);
        c_mon_ok  = bcd_in_range({3'b0, cur_cal[20:16]}, 8'h01, 8'h12);
        c_day_ok  = (cur_cal[23:21] != 3'd0);
        c_date_ok = bcd_in_range({2'b0, cur_cal[29:24]}, 8'h01, 8'h31);
        c_rsv     = cur_cal[7] | (|cur_cal[31:30]);

        a_sec_ok  = bcd_in_range({1'b0, talm_w[6:0]},   8'h00, 8'h59);
        a_min_ok  = bcd_in_range({1'b0, talm_w[14:8]},  8'h00, 8'h59);
        a_hour_ok = bcd_in_range({2'b0, talm_w[21:16]}, 8'h00, 8'h23);
        a_rsv     = talm_w[22] | (|talm_w[31:24]);

        m_mon_ok  = bcd_in_range({3'b0, calm_w[20:16]}, 8'h01, 8'h12);
        m_date_ok = bcd_in_range({2'b0, calm_w[29:24]}, 8'h01, 8'h31);
        m_rsv     = calm_w[30] | (|calm_w[22:21]) | (|calm_w[15:0]);

        bad[BAD_TIME] = !(t_sec_ok && t_min_ok && t_hour_ok) || t_rsv;
        bad[BAD_CAL]  = !(c_cent_ok && c_year_ok && c_mon_ok && c_day_ok && c_date_ok) || c_rsv;
        bad[BAD_TALM] = (talm_w[7]  && !a_sec_ok)  ||
                        (talm_w[15] && !a_min_ok)  ||
                        (talm_w[23] && !a_hour_ok) || a_rsv;
        bad[BAD_CALM] = (calm_w[23] && !m_mon_ok)  ||
                        (calm_w[31] && !m_date_ok) || m_rsv;
    end

endmodule

// File: rtl/rtcal_alarm_match.sv
module rtcal_alarm_match
    import rtcal_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  time_f_t now_t,
    input  cal_f_t  now_c,
    input  talm_f_t talm,
    input  calm_f_t calm,
    input  logic    suppress,
    output logic    alarm_evt
);

    logic any_en;
    logic fields_eq;
    logic match_c;
    logic match_q;

    always_comb begin
        any_en = talm.sec_en | talm.min_en | talm.hour_en | calm.mon_en | calm.date_en;
        fields_eq = (!talm.sec_en  || (talm.val.sec  == now_t.sec))  &&
                    (!talm.min_en  || (talm.val.min  == now_t.min))  &&
                    (!talm.hour_en || (talm.val.hour == now_t.hour)) &&
                    (!calm.mon_en  || (calm.val.mon  == now_c.mon))  &&
                    (!calm.date_en || (calm.val.date == now_c.date));
        match_c   = any_en && fields_eq && !suppress;
        alarm_evt = match_c && !match_q;
    end

    always_ff @(posedge clk) begin
        if (rst) match_q <= 1'b0;
        else     match_q <= match_c;
    end

    AST_ALARM_SINGLE: assert property (@(posedge clk) disable iff (rst)
        alarm_evt |=> !alarm_evt); // R3

endmodule

// File: rtl/rtcal_irq_ctrl.sv
module rtcal_irq_ctrl
    import rtcal_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_ev,
    input  logic [N-1:0] clr_st,
    input  logic [N-1:0] msk_set,
    input  logic [N-1:0] msk_clr,
    output logic [N-1:0] status,
    output logic [N-1:0] mask,
    output logic         irq
);

    for (genvar i = 0; i < N; i++) begin : g_src
        logic st_r;
        logic mk_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                st_r <= 1'b0;
                mk_r <= 1'b0;
            end else begin
                st_r <= set_ev[i] | (st_r & ~clr_st[i]);
                mk_r <= msk_set[i] | (mk_r & ~msk_clr[i]);
            end
        end

        assign status[i] = st_r;
        assign mask[i]   = mk_r;

        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            set_ev[i] |=> status[i]); // R8
        AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
            (clr_st[i] && !set_ev[i]) |=> !status[i]); // R7
        AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
            (msk_set[i] && !msk_clr[i]) |=> mask[i]); // R5
        AST_MASK_CLR: assert property (@(posedge clk) disable iff (rst)
            (msk_clr[i] && !msk_set[i]) |=> !mask[i]); // R6
    end

    assign irq = |(status & mask);

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq); // R9

endmodule

// File: rtl/rtcal_top.sv
module rtcal_top
    import rtcal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       cur_time,
    input  logic [31:0]       cur_cal,
    input  logic              ev_upd_ack,
    input  logic              ev_second,
    input  logic              ev_time,
    input  logic              ev_cal,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       alarm_time_word,
    output logic [31:0]       alarm_cal_word,
    output logic [4:0]        status,
    output logic [4:0]        irq_mask,
    output logic [3:0]        entry_bad,
    output logic              irq
);

    logic [WORD_W-1:0] talm_q, calm_q;
    time_f_t now_t;
    cal_f_t  now_c;
    talm_f_t talm_f;
    calm_f_t calm_f;
    logic    alm_evt;
    logic [NSRC-1:0] set_ev, clr_st, msk_set, msk_clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            talm_q <= '0;
            calm_q <= '0;
        end else if (reg_we) begin
            if (reg_addr == RA_TIME_ALM) talm_q <= reg_wdata;
            if (reg_addr == RA_CAL_ALM)  calm_q <= reg_wdata;
        end
    end

    always_comb begin
        now_t  = '{hour: cur_time[21:16], min: cur_time[14:8], sec: cur_time[6:0]};
        now_c  = '{date: cur_cal[29:24], mon: cur_cal[20:16]};
        talm_f = '{hour_en: talm_q[23], min_en: talm_q[15], sec_en: talm_q[7],
                   val: '{hour: talm_q[21:16], min: talm_q[14:8], sec: talm_q[6:0]}};
        calm_f = '{date_en: calm_q[31], mon_en: calm_q[23],
                   val: '{date: calm_q[29:24], mon: calm_q[20:16]}};

        set_ev          = '0;
        set_ev[SRC_UPD] = ev_upd_ack;
        set_ev[SRC_ALM] = alm_evt;
        set_ev[SRC_SEC] = ev_second;
        set_ev[SRC_TIM] = ev_time;
        set_ev[SRC_CAL] = ev_cal;

        msk_set = (reg_we && reg_addr == RA_IRQ_SET)  ? reg_wdata[NSRC-1:0] : '0;
        msk_clr = (reg_we && reg_addr == RA_IRQ_CLR)  ? reg_wdata[NSRC-1:0] : '0;
        clr_st  = (reg_we && reg_addr == RA_STAT_CLR) ? reg_wdata[NSRC-1:0] : '0;
    end

    rtcal_entry_check u_check (
        .cur_time (cur_time),
        .cur_cal  (cur_cal),
        .talm_w   (talm_q),
        .calm_w   (calm_q),
        .bad      (entry_bad)
    );

    rtcal_alarm_match u_match (
        .clk       (clk),
        .rst       (rst),
        .now_t     (now_t),
        .now_c     (now_c),
        .talm      (talm_f),
        .calm      (calm_f),
        .suppress  (entry_bad[BAD_TALM] | entry_bad[BAD_CALM]),
        .alarm_evt (alm_evt)
    );

    rtcal_irq_ctrl #(.N(NSRC)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .set_ev  (set_ev),
        .clr_st  (clr_st),
        .msk_set (msk_set),
        .msk_clr (msk_clr),
        .status  (status),
        .mask    (irq_mask),
        .irq     (irq)
    );

    assign alarm_time_word = talm_q;
    assign alarm_cal_word  = calm_q;

    AST_ALARM_TO_STATUS: assert property (@(posedge clk) disable iff (rst)
        alm_evt |=> status[SRC_ALM]); // R3
    AST_BAD_BLOCKS_ALARM: assert property (@(posedge clk) disable iff (rst)
        (entry_bad[BAD_TALM] || entry_bad[BAD_CALM]) |-> !alm_evt); // R11
    AST_RESET_CLEAN: assert property (@(posedge clk)
        $past(rst) |-> (status == '0 && irq_mask == '0 && !irq)); // R12

endmodule

// File: tb/rtcal_top_tb.sv
`timescale 1ns/1ps
module rtcal_top_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] cur_time, cur_cal;
    logic        ev_upd_ack, ev_second, ev_time, ev_cal;
    logic        reg_we;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] alarm_time_word, alarm_cal_word;
    logic [4:0]  status, irq_mask;
    logic [3:0]  entry_bad;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;

    localparam logic [31:0] BASE_T = 32'h0023_5959;
    localparam logic [31:0] BASE_C = 32'h3132_2020;
    localparam int NVEC = 12;
    // {time alarm, calendar alarm, time, calendar, alarm expected, entry_bad expected}
    localparam logic [132:0] VECS [0:NVEC-1] = '{
        {32'h0090_95B0, 32'h0000_0000, 32'h0010_1530, 32'h0121_2020, 1'b1, 4'h0},
        {32'h0090_95B0, 32'h0000_0000, 32'h0010_1531, 32'h0121_2020, 1'b0, 4'h0},
        {32'h0000_00B0, 32'h0000_0000, 32'h0007_4230, 32'h0121_2020, 1'b1, 4'h0},
        {32'h003F_7FB0, 32'h0000_0000, 32'h0001_0230, 32'h0121_2020, 1'b1, 4'h0},
        {32'h0000_0000, 32'h9586_0000, 32'h0010_1530, 32'h1566_2019, 1'b1, 4'h0},
        {32'h0000_0000, 32'h9586_0000, 32'h0010_1530, 32'h1466_2019, 1'b0, 4'h0},
        {32'h0000_00DA, 32'h0000_0000, 32'h0000_005A, 32'h0121_2020, 1'b0, 4'h5},
        {32'h0000_0000, 32'h0093_0000, 32'h0012_0000, 32'h0133_2020, 1'b0, 4'hA},
        {32'h0000_0000, 32'h0000_0000, 32'h0010_1530, 32'h0121_2020, 1'b0, 4'h0},
        {32'h00A4_0000, 32'h0000_0000, 32'h0024_0000, 32'h0121_2020, 1'b0, 4'h5},
        {32'h0000_0000, 32'h8000_0000, 32'h0010_1530, 32'h0021_2020, 1'b0, 4'hA},
        {32'h0100_00B0, 32'h0000_0000, 32'h0000_0030, 32'h0121_2020, 1'b0, 4'h4}
    };

    always #5 clk = ~clk;

    rtcal_top u_dut (
        .clk(clk), .rst(rst), .cur_time(cur_time), .cur_cal(cur_cal),
        .ev_upd_ack(ev_upd_ack), .ev_second(ev_second), .ev_time(ev_time), .ev_cal(ev_cal),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .alarm_time_word(alarm_time_word), .alarm_cal_word(alarm_cal_word),
        .status(status), .irq_mask(irq_mask), .entry_bad(entry_bad), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; cur_time = BASE_T; cur_cal = BASE_C;
        ev_upd_ack = 0; ev_second = 0; ev_time = 0; ev_cal = 0;
        reg_we = 0; reg_addr = '0; reg_wdata = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R12 reset state
        chk("R12 status", {27'b0, status}, 32'h0);
        chk("R12 mask", {27'b0, irq_mask}, 32'h0);
        chk("R12 irq", {31'b0, irq}, 32'h0);
        chk("R12 time alarm", alarm_time_word, 32'h0);
        chk("R12 cal alarm", alarm_cal_word, 32'h0);

        // R4 event sources
        ev_upd_ack = 1; ev_second = 1; ev_time = 1; ev_cal = 1;
        tick();
        ev_upd_ack = 0; ev_second = 0; ev_time = 0; ev_cal = 0;
        chk("R4 events", {27'b0, status}, 32'h1D);
        tick();
        chk("R4 sticky", {27'b0, status}, 32'h1D);
        chk("R9 irq masked off", {31'b0, irq}, 32'h0);

        // R5 / R6 mask strobes
        wr(3'd2, 32'h0000_0014);
        chk("R5 set", {27'b0, irq_mask}, 32'h14);
        chk("R9 irq on", {31'b0, irq}, 32'h1);
        wr(3'd2, 32'h0000_0001);
        chk("R5 zeros keep", {27'b0, irq_mask}, 32'h15);
        wr(3'd3, 32'h0000_0005);
        chk("R6 clear", {27'b0, irq_mask}, 32'h10);
        chk("R9 irq still on", {31'b0, irq}, 32'h1);
        wr(3'd3, 32'hFFFF_FFFF);
        chk("R6 clear all", {27'b0, irq_mask}, 32'h0);
        chk("R9 irq off", {31'b0, irq}, 32'h0);

        // R7 status clear
        wr(3'd4, 32'h0000_000C);
        chk("R7 partial clear", {27'b0, status}, 32'h11);

        // R8 set beats clear
        ev_second = 1'b1;
        wr(3'd4, 32'h0000_0004);
        ev_second = 1'b0;
        chk("R8 set wins", {27'b0, status}, 32'h15);
        wr(3'd4, 32'hFFFF_FFFF);
        chk("R7 clear all", {27'b0, status}, 32'h0);

        // R1 R2 R3 R10 R11 alarm vectors
        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] v_ta, v_ca, v_t, v_c;
            logic        v_ea;
            logic [3:0]  v_eb;
            {v_ta, v_ca, v_t, v_c, v_ea, v_eb} = VECS[i];
            cur_time = BASE_T; cur_cal = BASE_C;
            wr(3'd0, v_ta);
            wr(3'd1, v_ca);
            tick();
            wr(3'd4, 32'h0000_001F);
            cur_time = v_t; cur_cal = v_c;
            tick();
            chk($sformatf("R1 R2 R3 R11 alarm vec%0d", i), {31'b0, status[1]}, {31'b0, v_ea});
            chk($sformatf("R10 entry_bad vec%0d", i), {28'b0, entry_bad}, {28'b0, v_eb});
        end
        chk("R1 alarm word readback", alarm_time_word, 32'h0100_00B0);

        // R3 single set while match holds
        cur_time = BASE_T; cur_cal = BASE_C;
        wr(3'd0, 32'h0090_95B0);
        wr(3'd1, 32'h0);
        tick();
        wr(3'd4, 32'h1F);
        wr(3'd2, 32'h2);
        cur_time = 32'h0010_1530; cur_cal = 32'h0121_2020;
        tick();
        chk("R3 alarm set", {31'b0, status[1]}, 32'h1);
        chk("R9 alarm irq", {31'b0, irq}, 32'h1);
        wr(3'd4, 32'h2);
        tick();
        tick();
        chk("R3 no re-set while held", {31'b0, status[1]}, 32'h0);
        chk("R9 irq drops", {31'b0, irq}, 32'h0);
        cur_time = BASE_T;
        tick();
        cur_time = 32'h0010_1530;
        tick();
        chk("R3 re-arm after break", {31'b0, status[1]}, 32'h1);

        // R8 alarm set in same cycle as its clear
        cur_time = BASE_T;
        tick();
        wr(3'd4, 32'h1F);
        cur_time = 32'h0010_1530;
        wr(3'd4, 32'h2);
        chk("R8 alarm set wins", {31'b0, status[1]}, 32'h1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule